// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Barrel Shifter

This block is the combinational execute stage of a 32-bit RISC datapath. It takes two operands, a 5-bit shift distance and a 4-bit operation code. It returns a result word, a zero flag and a signed overflow flag. The operations are addition and subtraction, each in a trapping (signed) and a non-trapping (unsigned) form, bitwise AND and OR, signed set-less-than, and left and right shifts. Right shifts come in a zero-fill form and a sign-fill form. Load and store address generation also goes through the non-trapping add.

A separate enable input decides whether a signed overflow turns into a trap request for the exception logic. The shift distance always comes from its own 5-bit field, never from an operand. The value that is shifted is always operand B, and operand A plays no part in a shift. Operand selection and the register file sit outside this block.

Top module: `ialu_core`

## Requirements
- R1: Op code 0 (signed add) and op code 1 (unsigned add) give `result` = A + B modulo 2^32.
- R2: Op code 2 (signed subtract) and op code 3 (unsigned subtract) give `result` = A - B modulo 2^32.
- R3: `ovf` is 1 for op code 0 when A and B have the same sign bit and the sum's sign bit differs. It is 1 for op code 2 when A and B differ in sign and the difference's sign bit differs from A's. It is 0 for every other op code, including 1 and 3.
- R4: Op code 4 gives A AND B, and op code 5 gives A OR B.
- R5: Op code 6 gives 32'd1 when A is less than B as two's-complement numbers and 32'd0 otherwise. This holds even when A - B overflows.
- R6: Op code 7 gives B shifted left by `shamt` (0 to 31) with zeros filled in, and A has no effect on the result.
- R7: Op code 8 gives B shifted right by `shamt` with zeros filled in at the top, and A has no effect on the result.
- R8: Op code 9 gives B shifted right by `shamt` with copies of B[31] filled in at the top, and A has no effect on the result.
- R9: Op codes 10 to 15 give `result` = 0 and `ovf` = 0.
- R10: `zero` is 1 exactly when `result` is all zeros.
- R11: `trap_req` equals `ovf` AND `trap_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | First operand (rs) |
| opd_b | input | 32 | Second operand (rt), and the value that is shifted |
| shamt | input | 5 | Shift distance |
| op | input | 4 | Operation code |
| trap_en | input | 1 | Allows a signed overflow to raise a trap request |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of a trapping add or subtract |
| trap_req | output | 1 | Overflow trap request |

## Verification
The block has no stored state, so any internal fault shows at the ports in the same cycle as the inputs that expose it. A wrong stage in the shifter appears only for shift distances whose matching bit is set. A fault in the fill selection appears only when B[31] is 1. A fault in the overflow or less-than path appears only near the signed range limits. For this reason the random stimulus is biased toward extreme operands and every shift distance, and directed cases cover each of these boundaries.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_SLT  = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9
  } alu_op_e;

  // Signed overflow from the sign bits of the two adder inputs and the sum.
  function automatic logic add_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  // Signed less-than from the sign of a difference and its overflow.
  function automatic logic lt_from_diff(input logic diff_msb, input logic diff_ovf);
    return diff_msb ^ diff_ovf;
  endfunction

endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf_raw,
  output logic         less
);
  import ialu_pkg::*;

  logic [W-1:0] b_eff;

  assign b_eff   = b ^ {W{sub}};
  assign sum     = a + b_eff + W'(sub);
  assign ovf_raw = add_ovf(a[W-1], b_eff[W-1], sum[W-1]);
  assign less    = lt_from_diff(sum[W-1], ovf_raw);

endmodule

// File: rtl/ialu_shifter.sv
module ialu_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  res
);

  logic [W-1:0] val_rev;
  logic [W-1:0] out_rev;
  logic [W-1:0] stg [0:SW];
  logic         fill;

  // Left shifts reuse the right-shift stages on the bit-reversed value.
  generate
    for (genvar k = 0; k < W; k++) begin : g_rev
      assign val_rev[k] = val[W-1-k];
      assign out_rev[k] = stg[SW][W-1-k];
    end
  endgenerate

  assign fill   = arith & ~left & val[W-1];
  assign stg[0] = left ? val_rev : val;

  generate
    for (genvar i = 0; i < SW; i++) begin : g_stage
      localparam int D = 1 << i;
      assign stg[i+1] = amt[i] ? {{D{fill}}, stg[i][W-1:D]} : stg[i];
    end
  endgenerate

  assign res = left ? out_rev : stg[SW];

endmodule

// File: rtl/ialu_bitlogic.sv
module ialu_bitlogic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_or,
  output logic [W-1:0] res
);

  assign res = sel_or ? (a | b) : (a & b);

endmodule

// File: rtl/ialu_core.sv
module ialu_core #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  opd_a,
  input  logic [W-1:0]  opd_b,
  input  logic [SW-1:0] shamt,
  input  logic [3:0]    op,
  input  logic          trap_en,
  output logic [W-1:0]  result,
  output logic          zero,
  output logic          ovf,
  output logic          trap_req
);
  import ialu_pkg::*;

  alu_op_e      opc;
  logic         use_sub;
  logic         signed_op;
  logic [W-1:0] as_sum;
  logic         as_ovf_raw;
  logic         as_less;
  logic [W-1:0] sh_res;
  logic         sh_left;
  logic         sh_arith;
  logic [W-1:0] lg_res;

  assign opc       = alu_op_e'(op);
  assign use_sub   = (opc == OP_SUB) || (opc == OP_SUBU) || (opc == OP_SLT);
  assign signed_op = (opc == OP_ADD) || (opc == OP_SUB);
  assign sh_left   = (opc == OP_SLL);
  assign sh_arith  = (opc == OP_SRA);

  ialu_addsub #(.W(W)) u_addsub (
    .a(opd_a), .b(opd_b), .sub(use_sub),
    .sum(as_sum), .ovf_raw(as_ovf_raw), .less(as_less)
  );

  ialu_shifter #(.W(W), .SW(SW)) u_shift (
    .val(opd_b), .amt(shamt), .left(sh_left), .arith(sh_arith), .res(sh_res)
  );

  ialu_bitlogic #(.W(W)) u_logic (
    .a(opd_a), .b(opd_b), .sel_or(opc == OP_OR), .res(lg_res)
  );

  always_comb begin
    case (opc)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = as_sum;
      OP_AND, OP_OR:                    result = lg_res;
      OP_SLT:                           result = {{(W-1){1'b0}}, as_less};
      OP_SLL, OP_SRL, OP_SRA:           result = sh_res;
      default:                          result = '0;
    endcase
  end

  assign zero     = ~|result;
  assign ovf      = signed_op & as_ovf_raw;
  assign trap_req = ovf & trap_en;

endmodule

// File: rtl/ialu_checker.sv
module ialu_checker #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input logic [W-1:0]  opd_a,
  input logic [W-1:0]  opd_b,
  input logic [SW-1:0] shamt,
  input logic [3:0]    op,
  input logic          trap_en,
  input logic [W-1:0]  result,
  input logic          zero,
  input logic          ovf,
  input logic          trap_req
);
  import ialu_pkg::*;

  always_comb begin
    AST_NO_OVERFLOW: assert (!(ovf && op != OP_ADD && op != OP_SUB)); // R3
    AST_TRAP_GATED: assert (!(trap_req && !(ovf && trap_en))); // R11
    AST_SLT_ONE_BIT: assert (!(op == OP_SLT && result[W-1:1] != '0)); // R5
    AST_SRA_SIGN: assert (!(op == OP_SRA && result[W-1] != opd_b[W-1])); // R8
    AST_SRL_TOP: assert (!(op == OP_SRL && shamt != '0 && result[W-1])); // R7
    AST_SHIFT_NONE: assert (!((op == OP_SLL || op == OP_SRL || op == OP_SRA) && shamt == '0 && result != opd_b)); // R6
    AST_SUB_SELF_ZERO: assert (!((op == OP_SUB || op == OP_SUBU) && opd_a == opd_b && !zero)); // R10
    AST_ADD_WRAP: assert (!(op == OP_ADDU && result != opd_a + opd_b)); // R1
  end

endmodule

bind ialu_core ialu_checker #(.W(W), .SW(SW)) u_chk (
  .opd_a(opd_a), .opd_b(opd_b), .shamt(shamt), .op(op), .trap_en(trap_en),
  .result(result), .zero(zero), .ovf(ovf), .trap_req(trap_req)
);

// File: tb/sim_ialu_core.sv
module sim_ialu_core;

  logic        clk = 1'b0;
  logic [31:0] a, b, result;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic        ten, zero, ovf, trap_req;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  ialu_core u0 (
    .opd_a(a), .opd_b(b), .shamt(sh), .op(op), .trap_en(ten),
    .result(result), .zero(zero), .ovf(ovf), .trap_req(trap_req)
  );

  function automatic logic [31:0] exp_res(input logic [3:0] o, input logic [31:0] x,
                                          input logic [31:0] y, input logic [4:0] s);
    case (o)
      4'd0, 4'd1: return x + y;
      4'd2, 4'd3: return x - y;
      4'd4: return x & y;
      4'd5: return x | y;
      4'd6: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd7: return y << s;
      4'd8: return y >> s;
      4'd9: return $unsigned($signed(y) >>> s);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [32:0] w;
    if (o == 4'd0) w = {x[31], x} + {y[31], y};
    else if (o == 4'd2) w = {x[31], x} - {y[31], y};
    else return 1'b0;
    return w[32] != w[31];
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d actual=%h expected=%h", tag, op, a, b, sh, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [4:0] s, input logic te);
    logic [31:0] er;
    logic        eo;
    @(negedge clk);
    op = o; a = x; b = y; sh = s; ten = te;
    @(posedge clk);
    er = exp_res(o, x, y, s);
    eo = exp_ovf(o, x, y);
    chk(tag_of(o), result, er);
    chk("R3", {31'd0, ovf}, {31'd0, eo});
    chk("R10", {31'd0, zero}, {31'd0, er == 32'd0});
    chk("R11", {31'd0, trap_req}, {31'd0, eo & te});
  endtask

  function automatic logic [31:0] pick(input int unsigned r);
    case (r % 6)
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'hffffffff;
      3: return 32'h00000000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    op = 4'd0; a = '0; b = '0; sh = '0; ten = 1'b0;
    void'($urandom(32'd12345));
    // idle inputs: result 0, zero set (R10)
    run(4'd0, 32'h0, 32'h0, 5'd0, 1'b0);
    // R3 / R11 overflow and gating
    run(4'd0, 32'h7fffffff, 32'h1, 5'd0, 1'b1);
    run(4'd0, 32'h7fffffff, 32'h1, 5'd0, 1'b0);
    run(4'd1, 32'h7fffffff, 32'h1, 5'd0, 1'b1);
    run(4'd2, 32'h80000000, 32'h1, 5'd0, 1'b1);
    run(4'd3, 32'h80000000, 32'h1, 5'd0, 1'b1);
    run(4'd2, 32'h12345678, 32'h12345678, 5'd0, 1'b1);
    // R5 across the overflow boundary
    run(4'd6, 32'h80000000, 32'h1, 5'd0, 1'b0);
    run(4'd6, 32'h7fffffff, 32'hffffffff, 5'd0, 1'b0);
    run(4'd6, 32'h5, 32'h5, 5'd0, 1'b0);
    // R6 R7 R8 shift limits, A varied to show it has no effect
    run(4'd7, 32'hdeadbeef, 32'h1, 5'd31, 1'b0);
    run(4'd7, 32'h0, 32'h1, 5'd31, 1'b0);
    run(4'd8, 32'hffffffff, 32'h80000000, 5'd31, 1'b0);
    run(4'd9, 32'h0, 32'h80000000, 5'd31, 1'b0);
    run(4'd9, 32'h0, 32'h40000000, 5'd30, 1'b0);
    run(4'd8, 32'h1, 32'hcafef00d, 5'd0, 1'b0);
    // R9 unused codes
    run(4'd12, 32'h7fffffff, 32'h1, 5'd3, 1'b1);
    run(4'd15, 32'hffffffff, 32'hffffffff, 5'd31, 1'b1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  ro;
      logic [31:0] ra, rb;
      ro = 4'($urandom % 16);
      ra = pick($urandom);
      rb = pick($urandom);
      run(ro, ra, rb, 5'($urandom % 32), 1'($urandom % 2));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule